// File: doc/BRIEF.md
# Performance Counter Freeze Controller

This block owns a bank of four 32-bit event counters and the control register that governs them. Each cycle it builds one "enabled condition" from two sources. The first is a rising edge on one selectable bit of a free-running 64-bit time base. The second is a counter whose most significant bit is set, meaning it has gone negative. Counter 1 has its own enable for the negative condition. Counters 2 to 4 share a second enable.

When the enabled condition is present, the block can do three things, depending on the control fields:
- stop all counting by setting a global freeze flag;
- emit a one-cycle trigger pulse;
- emit a one-cycle exception pulse.

Freezing is armed only while trigger mode is off. In trigger mode a condition produces the trigger pulse and never sets the freeze flag. Software reaches the control register and the counters through a single write port. It reads them back on the `ctrl_o` and `count_o` outputs.

Control word layout, written at address 0 (bit positions are the ones the bench uses):

| Bits | Field |
|------|-------|
| 0 | freeze |
| 1 | freeze-on-condition |
| 2 | trigger mode |
| 4:3 | time-base select |
| 5 | time-base event enable |
| 6 | counter 1 negative enable |
| 7 | counters 2 to 4 negative enable |
| 8 | exception enable |

Addresses 1 to 4 load counters 1 to 4.

Top module: `pfc_freeze_ctrl`

## Requirements
- R1: After a synchronous reset, `ctrl_o`, every counter, `frozen_o`, `trig_o` and `exc_o` are all zero.
- R2: While the freeze bit (control bit 0) is 0, counter i increments by one on each clock edge where `evt_i[i-1]` is 1. A write to a counter's address (1..4) loads `wr_data` instead.
- R3: While the freeze bit is 1, no counter increments, whatever `evt_i` holds.
- R4: When freeze-on-condition (bit 1) is 1 and trigger mode (bit 2) is 0, an enabled condition present in a cycle sets the freeze bit at the next clock edge. From the edge after that, counting stops.
- R5: When trigger mode is 1, an enabled condition never sets the freeze bit. Instead, `trig_o` is 1 for exactly one cycle, starting one edge after the condition first appears.
- R6: When freeze-on-condition is 0, an enabled condition leaves the freeze bit at 0 and counting continues.
- R7: The time-base select (bits 4:3) picks which time-base bit is watched: code 0 → `tb_i[31]`, 1 → `tb_i[23]`, 2 → `tb_i[19]`, 3 → `tb_i[15]`. Other bits have no effect.
- R8: A time-base event occurs only when the selected bit changes from 0 to 1 between consecutive edges, and only while the time-base event enable (bit 5) is 1.
- R9: The edge detector compares the currently selected bit against the previous edge's sample of the previously selected bit. Rewriting the select so that it points at a bit holding 1, when the old bit was 0, therefore produces an event immediately.
- R10: Counter 1 raises a condition when its bit 31 is 1 and the counter-1 negative enable (bit 6) is 1. The enable for counters 2 to 4 has no effect on counter 1.
- R11: Counters 2 to 4 raise a condition when any of them has bit 31 set and the shared enable (bit 7) is 1. The counter-1 enable has no effect on them.
- R12: `exc_o` is 1 for exactly one cycle, one edge after the enabled condition first appears, and only if the exception enable (bit 8) is 1.
- R13: A software write to the control register takes priority over a hardware freeze set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | 0 = control word, 1..4 = counter 1..4 |
| wr_data | input | 32 | Write data |
| evt_i | input | 4 | Per-counter increment requests |
| tb_i | input | 64 | Time base value |
| ctrl_o | output | 9 | Current control word |
| count_o | output | 128 | Counters, counter 1 in bits 31:0 |
| frozen_o | output | 1 | Global freeze flag |
| trig_o | output | 1 | Trigger pulse |
| exc_o | output | 1 | Exception pulse |

## Verification
The bench targets the spurious edge that appears when the select is rewritten. A design that kept one history bit per tap would miss that edge, and the bench would see no exception pulse.

It checks that trigger mode suppresses the freeze even with freeze-on-condition set. An implementation that ignored trigger mode would stop counting there.

The two negative enables are crossed against the wrong counters. Shared wiring would then freeze where it must not.

A control write is placed on the same edge as a pending hardware freeze. If hardware won, `frozen_o` would read 1 where software wrote 0.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int NUM_CNT = 4;
    localparam int CNT_W   = 32;
    localparam int TB_W    = 64;
    localparam int ADDR_W  = 3;
    localparam int CTRL_W  = 9;

    // Control word: freeze sits in bit 0, exception enable in bit 8.
    typedef struct packed {
        logic       exc_en;
        logic       negx_en;
        logic       neg1_en;
        logic       tb_en;
        logic [1:0] tb_sel;
        logic       trig_mode;
        logic       fz_on_cond;
        logic       freeze;
    } ctrl_t;

    typedef struct packed {
        logic tb_evt;
        logic neg1;
        logic negx;
    } cond_src_t;

    // Tap chosen by the 2-bit select, numbered from the LSB.
    function automatic logic tb_pick(logic [TB_W-1:0] tb, logic [1:0] sel);
        logic r;
        case (sel)
            2'd0:    r = tb[31];
            2'd1:    r = tb[23];
            2'd2:    r = tb[19];
            default: r = tb[15];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfc_tb_edge.sv
module pfc_tb_edge
    import pfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [TB_W-1:0] tb_i,
    input  logic [1:0]      sel_i,
    input  logic            en_i,
    output logic            evt_o
);

    logic tap_now;
    logic tap_prev;

    always_comb tap_now = tb_pick(tb_i, sel_i);

    // Sample whatever is selected now; a select change compares new vs old tap.
    always_ff @(posedge clk) begin
        if (rst) tap_prev <= 1'b0;
        else     tap_prev <= tap_now;
    end

    always_comb evt_o = en_i & tap_now & ~tap_prev;

    // R8: with the select held, an event cannot repeat on the next cycle
    assert_tb_single_R8: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> (!evt_o || (sel_i != $past(sel_i))));

endmodule

// File: rtl/pfc_cond.sv
module pfc_cond
    import pfc_pkg::*;
#(
    parameter int N = NUM_CNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tb_evt_i,
    input  logic [N-1:0] msb_i,
    input  ctrl_t        ctrl_i,
    output logic         cond_o,
    output logic         trig_o,
    output logic         exc_o
);

    cond_src_t src;
    logic      cond_q;
    logic      cond_rise;

    always_comb begin
        src.tb_evt = tb_evt_i;
        src.neg1   = ctrl_i.neg1_en & msb_i[0];
        src.negx   = ctrl_i.negx_en & (|msb_i[N-1:1]);
        cond_o     = |src;
        cond_rise  = cond_o & ~cond_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
            trig_o <= 1'b0;
            exc_o  <= 1'b0;
        end else begin
            cond_q <= cond_o;
            trig_o <= cond_rise & ctrl_i.trig_mode;
            exc_o  <= cond_rise & ctrl_i.exc_en;
        end
    end

    assert_exc_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        exc_o |=> !exc_o);

    assert_trig_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

endmodule

// File: rtl/pfc_counter.sv
module pfc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_data_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst)        cnt_o <= '0;
        else if (ld_i)  cnt_o <= ld_data_i;
        else if (inc_i) cnt_o <= cnt_o + W'(1);
    end

    // R3: a gated-off counter holds its value unless loaded
    assert_hold_when_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !ld_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pfc_freeze_ctrl.sv
module pfc_freeze_ctrl
    import pfc_pkg::*;
#(
    parameter int N_CNT = NUM_CNT,
    parameter int CW    = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [N_CNT-1:0]  evt_i,
    input  logic [TB_W-1:0]   tb_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [N_CNT*CW-1:0] count_o,
    output logic              frozen_o,
    output logic              trig_o,
    output logic              exc_o
);

    ctrl_t            ctrl;
    logic             ctrl_wr;
    logic             tb_evt;
    logic             cond;
    logic             hw_freeze;
    logic [N_CNT-1:0] msb;

    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == '0);
        hw_freeze = cond && ctrl.fz_on_cond && !ctrl.trig_mode;
    end

    // Software write wins over the hardware set in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)            ctrl <= '0;
        else if (ctrl_wr)   ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        else if (hw_freeze) ctrl.freeze <= 1'b1;
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        logic          ld;
        logic          inc;
        logic [CW-1:0] val;
        always_comb begin
            ld  = wr_en && (wr_addr == ADDR_W'(i + 1));
            inc = evt_i[i] && !ctrl.freeze;
        end
        pfc_counter #(.W(CW)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .inc_i     (inc),
            .ld_i      (ld),
            .ld_data_i (wr_data),
            .cnt_o     (val)
        );
        assign count_o[i*CW +: CW] = val;
        assign msb[i]              = val[CW-1];
    end

    pfc_tb_edge u_tb (
        .clk   (clk),
        .rst   (rst),
        .tb_i  (tb_i),
        .sel_i (ctrl.tb_sel),
        .en_i  (ctrl.tb_en),
        .evt_o (tb_evt)
    );

    pfc_cond #(.N(N_CNT)) u_cond (
        .clk      (clk),
        .rst      (rst),
        .tb_evt_i (tb_evt),
        .msb_i    (msb),
        .ctrl_i   (ctrl),
        .cond_o   (cond),
        .trig_o   (trig_o),
        .exc_o    (exc_o)
    );

    assign ctrl_o   = ctrl;
    assign frozen_o = ctrl.freeze;

    assert_freeze_set_R4: assert property (@(posedge clk) disable iff (rst)
        (cond && ctrl.fz_on_cond && !ctrl.trig_mode && !ctrl_wr) |=> frozen_o);

    assert_trig_no_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.trig_mode && !ctrl.freeze && !ctrl_wr) |=> !frozen_o);

    assert_sw_priority_R13: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_o == $past(wr_data[CTRL_W-1:0])));

endmodule

// File: tb/pfc_freeze_ctrl_bench.sv
module pfc_freeze_ctrl_bench;
    import pfc_pkg::*;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [2:0]   wr_addr;
    logic [31:0]  wr_data;
    logic [3:0]   evt_i;
    logic [63:0]  tb_i;
    logic [8:0]   ctrl_o;
    logic [127:0] count_o;
    logic         frozen_o, trig_o, exc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pfc_freeze_ctrl u_pfc_freeze_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt_i(evt_i), .tb_i(tb_i), .ctrl_o(ctrl_o), .count_o(count_o),
        .frozen_o(frozen_o), .trig_o(trig_o), .exc_o(exc_o)
    );

    // control word bits
    localparam logic [31:0] FRZ = 32'h001, FOC = 32'h002, TRG = 32'h004;
    localparam logic [31:0] TBE = 32'h020, N1E = 32'h040, NXE = 32'h080, EXE = 32'h100;

    function automatic logic [31:0] sel_w(int code);
        return 32'(code) << 3;
    endfunction

    function automatic logic [31:0] cnt(int i);
        return count_o[i*32 +: 32];
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; evt_i = '0; tb_i = '0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ctrl", 32'(ctrl_o), 0);
        for (int i = 0; i < 4; i++) chk("R1 counter", cnt(i), 0);
        chk("R1 outs", {29'd0, frozen_o, trig_o, exc_o}, 0);
    endtask

    task automatic t_count();
        do_reset();
        evt_i = 4'b0101;
        repeat (3) step();
        evt_i = 4'b0010;
        step();
        evt_i = 0;
        chk("R2 cnt1", cnt(0), 3);
        chk("R2 cnt2", cnt(1), 1);
        chk("R2 cnt3", cnt(2), 3);
        chk("R2 cnt4", cnt(3), 0);
        wr(3'd4, 32'h0000_1234);
        chk("R2 load", cnt(3), 32'h1234);
    endtask

    task automatic t_freeze_blocks();
        do_reset();
        wr(3'd0, FRZ);
        evt_i = 4'b1111;
        repeat (3) step();
        chk("R3 frozen", {31'd0, frozen_o}, 1);
        for (int i = 0; i < 4; i++) chk("R3 held", cnt(i), 0);
        evt_i = 0;
        wr(3'd0, 0);
        evt_i = 4'b1000;
        step();
        evt_i = 0;
        chk("R3 resumes", cnt(3), 1);
    endtask

    task automatic t_freeze_on_cond();
        do_reset();
        wr(3'd0, FOC | N1E | EXE);
        wr(3'd1, 32'h8000_0000);   // condition present after this edge
        evt_i = 4'b0010;
        step();                    // freeze set, exception pulse
        chk("R4 frozen", {31'd0, frozen_o}, 1);
        chk("R12 exc", {31'd0, exc_o}, 1);
        chk("R4 counted in set cycle", cnt(1), 1);
        step();
        chk("R12 exc one cycle", {31'd0, exc_o}, 0);
        chk("R4 no count after", cnt(1), 1);
        evt_i = 0;
    endtask

    task automatic t_trigger();
        do_reset();
        wr(3'd0, FOC | TRG | N1E);
        wr(3'd1, 32'h8000_0000);
        evt_i = 4'b0100;
        step();
        chk("R5 trig", {31'd0, trig_o}, 1);
        chk("R5 no freeze", {31'd0, frozen_o}, 0);
        chk("R12 exc gated", {31'd0, exc_o}, 0);
        step();
        evt_i = 0;
        chk("R5 trig one cycle", {31'd0, trig_o}, 0);
        chk("R5 still counting", cnt(2), 2);
        chk("R5 no freeze later", {31'd0, frozen_o}, 0);
    endtask

    task automatic t_no_foc();
        do_reset();
        wr(3'd0, N1E | EXE);
        wr(3'd1, 32'h8000_0000);
        evt_i = 4'b0001;
        repeat (2) step();
        evt_i = 0;
        chk("R6 no freeze", {31'd0, frozen_o}, 0);
        chk("R6 counting", cnt(0), 32'h8000_0002);
    endtask

    task automatic t_tb_select();
        int taps[4] = '{31, 23, 19, 15};
        for (int c = 0; c < 4; c++) begin
            do_reset();
            wr(3'd0, TBE | EXE | sel_w(c));
            tb_i = 64'd1 << taps[(c + 1) % 4];   // unselected tap rises
            step(); step();
            chk("R7 other tap ignored", {31'd0, exc_o}, 0);
            tb_i = 0;
            step();
            tb_i = 64'd1 << taps[c];
            step();
            chk("R7 selected tap", {31'd0, exc_o}, 1);
            step();
            chk("R8 single event", {31'd0, exc_o}, 0);
            tb_i = 0;
            step();
            chk("R8 falling edge ignored", {31'd0, exc_o}, 0);
        end
    endtask

    task automatic t_tb_enable();
        do_reset();
        wr(3'd0, EXE | FOC);
        tb_i = 64'h8000_0000;
        step(); step();
        chk("R8 disabled no exc", {31'd0, exc_o}, 0);
        chk("R8 disabled no freeze", {31'd0, frozen_o}, 0);
    endtask

    task automatic t_spurious();
        do_reset();
        tb_i = 64'h0080_0000;          // bit 23 high, bit 31 low
        wr(3'd0, TBE | EXE);           // select code 0 watches bit 31
        step();
        chk("R9 quiet before", {31'd0, exc_o}, 0);
        wr(3'd0, TBE | EXE | sel_w(1)); // now bit 23, previous sample 0
        step();
        chk("R9 spurious edge", {31'd0, exc_o}, 1);
    endtask

    task automatic t_neg_enables();
        do_reset();
        wr(3'd0, FOC | NXE);
        wr(3'd1, 32'h8000_0000);
        step();
        chk("R10 shared enable ignores cnt1", {31'd0, frozen_o}, 0);
        do_reset();
        wr(3'd0, FOC | N1E);
        wr(3'd4, 32'hF000_0000);
        step();
        chk("R11 cnt1 enable ignores others", {31'd0, frozen_o}, 0);
        do_reset();
        wr(3'd0, FOC | NXE);
        wr(3'd3, 32'h8000_0005);
        step();
        chk("R11 any other counter", {31'd0, frozen_o}, 1);
        do_reset();
        wr(3'd0, FOC | N1E);
        wr(3'd1, 32'h7FFF_FFFF);
        chk("R10 positive no freeze", {31'd0, frozen_o}, 0);
        evt_i = 4'b0001;
        step();                         // counter becomes negative
        evt_i = 0;
        step();
        chk("R10 negative freezes", {31'd0, frozen_o}, 1);
    endtask

    task automatic t_sw_priority();
        do_reset();
        wr(3'd0, FOC | N1E);
        wr(3'd1, 32'h8000_0000);        // hardware would set freeze at next edge
        wr(3'd0, FOC | N1E);            // same edge: software writes freeze=0
        chk("R13 software wins", 32'(ctrl_o), FOC | N1E);
        step();
        chk("R13 hardware sets after", {31'd0, frozen_o}, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_freeze_blocks();
        t_freeze_on_cond();
        t_trigger();
        t_no_foc();
        t_tb_select();
        t_tb_enable();
        t_spurious();
        t_neg_enables();
        t_sw_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule